// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Writer

This block takes 64-bit command writes and turns each one into a single 32-bit update of a register in another core's register space. A command word carries four things: the target core number, the target address, a four-bit per-byte keep mask and a 32-bit payload. The block first reads the target word when any keep bit is set. It then merges the kept old bytes with the new payload bytes and writes the result back. If no keep bit is set, it skips the read and writes the payload in full.

Two command registers exist. A write to the mail-send offset aims at one of eight mailbox words at a fixed base in the target core's space. A write to the any-send offset aims at any 16-bit address in that space. The block drives a read port and a write port toward the shared target register storage. It pulses `done` when a command ends, and raises `err` on the same cycle if the core number was not valid. While a command is in progress the block holds `cmd_ready` low, so the next command waits.

Top module: `mbox_merge_writer`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `busy`, `rd_en`, `wr_en`, `done` and `err` are all 0.
- R2: A full 8-byte command at offset 0x000 (mail-send) writes to address MBOX_BASE + 0x20 + 4 × cmd_data[4:2]. The default MBOX_BASE is 0x1000.
- R3: A full 8-byte command at offset 0x008 (any-send) writes to address cmd_data[15:0].
- R4: cmd_data[25:16] names the target core, and both `rd_core` and `wr_core` carry it. A core number that is not below NUM_CORES (default 4) makes `done` and `err` pulse together, and no read or write is made.
- R5: cmd_data[27+i] set keeps byte i (bits 8i+7:8i) of the word read from the target. A clear bit takes that byte from cmd_data[32+8i+7:32+8i]. Byte 0 is the least significant, so the layout is little-endian.
- R6: When cmd_data[30:27] is zero, the block makes no read and writes cmd_data[63:32] unchanged.
- R7: A command at any 12-bit offset other than 0x000 or 0x008, or one with `cmd_full` low (not an 8-byte access), makes no read and no write. It pulses `done` with `err` at 0 one cycle after it is accepted.
- R8: Timing counts from the accepting edge. A masked command has `rd_en` in cycle 1, `wr_en` in cycle 2 and `done` in cycle 3. An unmasked command has `wr_en` in cycle 1 and `done` in cycle 2. Each of these is high for one cycle only.
- R9: From acceptance until `done`, `busy` is 1 and `cmd_ready` is 0. A command offered in that time is held off and is accepted once the current one ends.
- R10: A write that follows a read goes to the same core and address as that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write request |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_addr | input | 12 | Command register offset |
| cmd_full | input | 1 | Access is 8 bytes wide |
| cmd_data | input | 64 | Command word |
| busy | output | 1 | Command in progress |
| rd_en | output | 1 | Target read strobe |
| rd_core | output | 10 | Target core for read |
| rd_addr | output | 16 | Target address for read |
| rd_data | input | 32 | Target read data, valid in the same cycle as rd_en |
| wr_en | output | 1 | Target write strobe |
| wr_core | output | 10 | Target core for write |
| wr_addr | output | 16 | Target address for write |
| wr_data | output | 32 | Merged write data |
| done | output | 1 | Command finished (one-cycle pulse) |
| err | output | 1 | Decode error, valid with done |

## Verification
The assertions check the following on every cycle:
- the ordering of the strobes: a read is always followed by a write, and a write is always followed by `done`;
- the three strobes never overlap;
- a write that follows a read uses the same core and address as the read;
- `err` only appears together with `done`, and never directly after a write.

Some behaviours only the bench's scenarios can show, because the payload and mask are not visible at the ports afterwards:
- the byte merge under several keep masks;
- the computed mailbox and any-send addresses;
- the silent handling of stray offsets and narrow accesses;
- holding a second command off until the first one ends.

// File: rtl/mbox_merge_writer.sv
module mbox_merge_writer #(
  parameter int          NUM_CORES = 4,
  parameter logic [15:0] MBOX_BASE = 16'h1000,
  parameter logic [11:0] MAIL_OFS  = 12'h000,
  parameter logic [11:0] ANY_OFS   = 12'h008
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [11:0] cmd_addr,
  input  logic        cmd_full,
  input  logic [63:0] cmd_data,
  output logic        busy,
  output logic        rd_en,
  output logic [9:0]  rd_core,
  output logic [15:0] rd_addr,
  input  logic [31:0] rd_data,
  output logic        wr_en,
  output logic [9:0]  wr_core,
  output logic [15:0] wr_addr,
  output logic [31:0] wr_data,
  output logic        done,
  output logic        err
);
  localparam int NB = 4;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_DONE} st_t;
  st_t state;

  logic [9:0]    core_q;
  logic [15:0]   addr_q;
  logic [NB-1:0] keep_q;
  logic [31:0]   pay_q, old_q;
  logic          err_q;

  wire        take     = cmd_valid && cmd_ready;
  wire        is_mail  = cmd_addr == MAIL_OFS;
  wire        is_any   = cmd_addr == ANY_OFS;
  wire [9:0]  core_d   = cmd_data[25:16];
  wire        core_ok  = int'(core_d) < NUM_CORES;
  wire [3:0]  keep_d   = cmd_data[30:27];
  wire [15:0] mail_adr = MBOX_BASE + 16'h0020 + {11'd0, cmd_data[4:2], 2'b00};
  wire        unused_bits = ^{cmd_data[31], cmd_data[26]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      err_q  <= 1'b0;
      core_q <= '0;
      addr_q <= '0;
      keep_q <= '0;
      pay_q  <= '0;
      old_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          core_q <= core_d;
          addr_q <= is_mail ? mail_adr : cmd_data[15:0];
          keep_q <= keep_d;
          pay_q  <= cmd_data[63:32];
          if (!cmd_full || !(is_mail || is_any)) begin
            err_q <= 1'b0;
            state <= S_DONE;
          end else if (!core_ok) begin
            err_q <= 1'b1;
            state <= S_DONE;
          end else begin
            err_q <= 1'b0;
            state <= (keep_d != '0) ? S_READ : S_WRITE;
          end
        end
        S_READ: begin
          old_q <= rd_data;
          state <= S_WRITE;
        end
        S_WRITE: state <= S_DONE;
        default: begin
          err_q <= 1'b0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign wr_data[8*i +: 8] = keep_q[i] ? old_q[8*i +: 8] : pay_q[8*i +: 8];
  end

  assign cmd_ready = state == S_IDLE;
  assign busy      = state != S_IDLE;
  assign rd_en     = state == S_READ;
  assign wr_en     = state == S_WRITE;
  assign done      = state == S_DONE;
  assign err       = done && err_q;
  assign rd_core   = core_q;
  assign wr_core   = core_q;
  assign rd_addr   = addr_q;
  assign wr_addr   = addr_q;
endmodule

module mbox_merge_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        wr_en,
  input logic        done,
  input logic        err,
  input logic [9:0]  rd_core,
  input logic [15:0] rd_addr,
  input logic [9:0]  wr_core,
  input logic [15:0] wr_addr
);
  // R8
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> wr_en);
  // R8
  write_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> done);
  // R8
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en, wr_en, done}));
  // R10
  same_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (wr_core == $past(rd_core) && wr_addr == $past(rd_addr)));
  // R4
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R4
  no_write_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !err);
endmodule

bind mbox_merge_writer mbox_merge_writer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .done(done),
  .err(err), .rd_core(rd_core), .rd_addr(rd_addr), .wr_core(wr_core),
  .wr_addr(wr_addr)
);

// File: tb/mbox_merge_writer_tb.sv
module mbox_merge_writer_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_full = 0;
  logic [11:0] cmd_addr = 0;
  logic [63:0] cmd_data = 0;
  logic        cmd_ready, busy, rd_en, wr_en, done, err;
  logic [9:0]  rd_core, wr_core;
  logic [15:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;

  logic [31:0] mem [4][64];
  int rd_cnt = 0, wr_cnt = 0;
  logic [9:0]  last_core;
  logic [15:0] last_addr;
  logic [31:0] last_data;
  int checks = 0, fails = 0, cyc;
  logic got_err;

  always #2.5 clk = ~clk;

  mbox_merge_writer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_full(cmd_full), .cmd_data(cmd_data), .busy(busy),
    .rd_en(rd_en), .rd_core(rd_core), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_core(wr_core), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .err(err)
  );

  assign rd_data = mem[rd_core[1:0]][rd_addr[7:2]];

  always @(posedge clk) begin
    if (rd_en) rd_cnt <= rd_cnt + 1;
    if (wr_en) begin
      wr_cnt <= wr_cnt + 1;
      mem[wr_core[1:0]][wr_addr[7:2]] <= wr_data;
      last_core <= wr_core;
      last_addr <= wr_addr;
      last_data <= wr_data;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic [31:0] pay, logic [3:0] keep,
                                     logic [9:0] core, logic [15:0] lo);
    return {pay, 1'b0, keep, 1'b0, core, lo};
  endfunction

  task automatic issue(input logic [11:0] a, input logic full, input logic [63:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_addr = a; cmd_full = full; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 0;
    cyc = 0; got_err = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cyc++;
      if (done) begin got_err = err; break; end
    end
  endtask

  task automatic t_reset();
    chk("R1 ready", cmd_ready, 1);
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {rd_en, wr_en, done, err}, 0);
  endtask

  task automatic t_mail_plain();
    int r0 = rd_cnt, w0 = wr_cnt;
    issue(12'h000, 1, mk(32'hCAFE_0001, 4'h0, 10'd2, 16'h0014));
    chk("R2 addr", last_addr, 16'h1034);
    chk("R4 core", last_core, 2);
    chk("R6 data", last_data, 32'hCAFE_0001);
    chk("R6 no read", rd_cnt - r0, 0);
    chk("R8 done cycle unmasked", cyc, 2);
    chk("R2 one write", wr_cnt - w0, 1);
  endtask

  task automatic t_any_merge();
    int r0 = rd_cnt;
    mem[1][17] = 32'hA1B2_C3D4;
    issue(12'h008, 1, mk(32'h1122_3344, 4'b0101, 10'd1, 16'h0044));
    chk("R3 addr", last_addr, 16'h0044);
    chk("R5 merge 0101", last_data, 32'h11B2_33D4);
    chk("R8 done cycle masked", cyc, 3);
    chk("R10 read once", rd_cnt - r0, 1);
    mem[3][9] = 32'h5566_7788;
    issue(12'h000, 1, mk(32'hFFFF_FFFF, 4'b1000, 10'd3, 16'h0004));
    chk("R5 merge 1000", last_data, 32'h55FF_FFFF);
    chk("R2 addr idx1", last_addr, 16'h1024);
    mem[0][40] = 32'hDEAD_BEEF;
    issue(12'h008, 1, mk(32'h0000_0000, 4'b1111, 10'd0, 16'h00A0));
    chk("R5 keep all", mem[0][40], 32'hDEAD_BEEF);
  endtask

  task automatic t_bad_core();
    int r0 = rd_cnt, w0 = wr_cnt;
    issue(12'h008, 1, mk(32'h1234_5678, 4'b0011, 10'd4, 16'h0010));
    chk("R4 err", got_err, 1);
    chk("R4 no access", {rd_cnt - r0, wr_cnt - w0}, 0);
    issue(12'h000, 1, mk(32'h1234_5678, 4'b0000, 10'h3FF, 16'h0000));
    chk("R4 err max core", got_err, 1);
    chk("R4 no write", wr_cnt - w0, 0);
  endtask

  task automatic t_ignored();
    int r0 = rd_cnt, w0 = wr_cnt;
    issue(12'h010, 1, mk(32'h1, 4'b0001, 10'd1, 16'h0008));
    chk("R7 odd offset err", got_err, 0);
    chk("R7 odd offset cycle", cyc, 1);
    issue(12'h000, 0, mk(32'h2, 4'b0000, 10'd1, 16'h0008));
    chk("R7 narrow err", got_err, 0);
    chk("R7 narrow cycle", cyc, 1);
    issue(12'h800, 1, mk(32'h3, 4'b0000, 10'd1, 16'h0008));
    chk("R7 high offset", {rd_cnt - r0, wr_cnt - w0}, 0);
  endtask

  task automatic t_stall();
    int w0 = wr_cnt;
    int low = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_addr = 12'h008; cmd_full = 1;
    cmd_data = mk(32'hAAAA_0001, 4'b0000, 10'd2, 16'h0080);
    @(posedge clk); #1;
    cmd_data = mk(32'hBBBB_0002, 4'b0000, 10'd2, 16'h0084);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (!cmd_ready && busy) low++;
    end
    chk("R9 held off", low, 2);
    @(negedge clk);
    chk("R9 second accepted ready", cmd_ready, 1);
    @(posedge clk); #1;
    cmd_valid = 0;
    repeat (3) @(negedge clk);
    chk("R9 both written", wr_cnt - w0, 2);
    chk("R9 first data", mem[2][32], 32'hAAAA_0001);
    chk("R9 second data", mem[2][33], 32'hBBBB_0002);
  endtask

  initial begin
    for (int c = 0; c < 4; c++)
      for (int j = 0; j < 64; j++) mem[c][j] = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mail_plain();
    t_any_merge();
    t_bad_core();
    t_ignored();
    t_stall();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule